// File: doc/BRIEF.md
# IPv4 Header Validator with TTL Rewrite

This block sits in the forwarding path of a router line card. It takes in a fixed IPv4 header of five 32-bit words with no options, one word per transfer on a valid/ready input stream. It checks that the header is fit to forward. If it is, it hands the header on with the time-to-live lowered by one and a corrected checksum. If it is not, it hands the header on unchanged, marked for dropping, with a reason code. Payload, fragments, options, route lookup and error messages are handled elsewhere.

The checksum is not recomputed over the whole header. It is patched from the old checksum and the 16-bit halfword that holds TTL and protocol. The patched value equals a full recomputation. The output is a single-beat result carrying the whole header, a forward flag and a reason code, under its own valid/ready pair.

Back-pressure works as follows. `in_ready` is high exactly when the result register is empty or is being taken in the same cycle. While a result waits with `out_ready` low, no input word is taken, including words in the middle of a header. A result stays stable until it is taken.

Top module: `ipv4_hdr_check`

## Requirements
- R1: An input word transfers on a rising edge where `in_valid` and `in_ready` are both high. Five transfers form one header: the first is word 0, and word 0 is placed at `hdr[159:128]`, word k at `hdr[159-32k -: 32]`. Gaps in `in_valid` between words are allowed. `out_valid` rises on the edge that takes the fifth word.
- R2: A version field (word 0 bits 31:28) other than 4 gives `out_reason` = 1 and `out_fwd` = 0.
- R3: A header-length field (word 0 bits 27:24) other than 5 gives reason 2. Values below 5 are malformed, and values above 5 announce options that this block does not carry.
- R4: Take the one's-complement sum, with end-around carry, of the ten 16-bit halfwords, the checksum included. If it is not 16'hFFFF, the result is reason 3.
- R5: A TTL (word 2 bits 31:24) of 0 or 1 gives reason 4.
- R6: When several checks fail, the lowest code among 1, 2, 3 and 4 is reported.
- R7: A header that passes every check gives `out_fwd` = 1 and reason 0. The TTL is lowered by one. Word 2 bits 15:0 hold the checksum of the modified header, equal to a full recomputation. All other bits are unchanged.
- R8: A dropped header is output bit-for-bit as received.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, no word is taken, and `out_hdr`, `out_fwd` and `out_reason` hold.
- R10: Each header yields exactly one result. `out_valid` falls after the result is taken unless a new header completes on that same edge.
- R11: Reset clears the output register and the word count. After reset `out_valid` = 0 and `in_ready` = 1, and a header cut short by reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block takes the input word |
| in_data | input | 32 | Header word, word 0 first |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_hdr | output | 160 | Header out, word 0 at bits 159:128 |
| out_fwd | output | 1 | 1 = forward, 0 = drop |
| out_reason | output | 3 | 0 ok, 1 version, 2 length, 3 checksum, 4 TTL |

## Verification
Two things can happen on the same clock edge: a held result is handed downstream, and the first word of the next header is taken. Both hang on `out_ready`. The bench stalls the output with a next word already offered and checks that nothing moves and the result stays put. It then raises `out_ready` and checks that the old result leaves once and that the next header still yields its own correct result. A stream of headers from a table, each failing one or several checks, is judged against a checksum and TTL model written in the bench from the requirements.

// File: rtl/ipv4_chk_pkg.sv
package ipv4_chk_pkg;
  localparam int WORD_W    = 32;
  localparam int HDR_WORDS = 5;
  localparam int HDR_BITS  = WORD_W * HDR_WORDS;
  localparam int HW_CNT    = HDR_BITS / 16;
  // word k occupies hdr[HDR_BITS-1-WORD_W*k -: WORD_W]
  localparam int W0_BASE   = HDR_BITS - WORD_W;
  localparam int W2_BASE   = HDR_BITS - 3 * WORD_W;
  localparam int VER_POS   = W0_BASE + 28;
  localparam int IHL_POS   = W0_BASE + 24;
  localparam int TTL_POS   = W2_BASE + 24;
  localparam int PROTO_POS = W2_BASE + 16;
  localparam int CSUM_POS  = W2_BASE;

  typedef enum logic [2:0] {
    RSN_OK       = 3'd0,
    RSN_VERSION  = 3'd1,
    RSN_LENGTH   = 3'd2,
    RSN_CHECKSUM = 3'd3,
    RSN_TTL      = 3'd4
  } drop_rsn_e;

  // 16-bit one's-complement addition with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  // folded one's-complement sum over all halfwords of a header
  function automatic logic [15:0] hdr_fold(input logic [HDR_BITS-1:0] h);
    logic [15:0] acc;
    acc = 16'h0000;
    for (int i = 0; i < HW_CNT; i++) acc = oc_add(acc, h[i*16 +: 16]);
    return acc;
  endfunction
endpackage

// File: rtl/ipv4_hdr_collect.sv
module ipv4_hdr_collect
  import ipv4_chk_pkg::*;
#(
  parameter int WORDS = HDR_WORDS,
  parameter int W     = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  input  logic             accept_en,
  output logic             in_ready,
  output logic             hdr_done,
  output logic [W*WORDS-1:0] hdr
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);
  localparam int SH_W = W * (WORDS - 1);

  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic             fire;

  assign in_ready = accept_en;
  assign fire     = in_valid && accept_en;
  assign hdr_done = fire && (cnt == LAST);
  assign hdr      = {sh, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (fire) begin
      sh  <= {sh[SH_W-W-1:0], in_data};
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_en |=> ($stable(cnt) && $stable(sh)));
endmodule

// File: rtl/ipv4_hdr_verify.sv
module ipv4_hdr_verify
  import ipv4_chk_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr,
  output drop_rsn_e           rsn
);
  logic [3:0] ver;
  logic [3:0] ihl;
  logic [7:0] ttl;
  logic       sum_ok;

  assign ver    = hdr[VER_POS +: 4];
  assign ihl    = hdr[IHL_POS +: 4];
  assign ttl    = hdr[TTL_POS +: 8];
  assign sum_ok = (hdr_fold(hdr) == 16'hFFFF);

  // priority: version, length, checksum, TTL
  always_comb begin
    if (ver != 4'd4)          rsn = RSN_VERSION;
    else if (ihl != 4'd5)     rsn = RSN_LENGTH;
    else if (!sum_ok)         rsn = RSN_CHECKSUM;
    else if (ttl <= 8'd1)     rsn = RSN_TTL;
    else                      rsn = RSN_OK;
  end
endmodule

// File: rtl/ipv4_ttl_rewrite.sv
module ipv4_ttl_rewrite
  import ipv4_chk_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr,
  output logic [HDR_BITS-1:0] hdr_new
);
  logic [7:0]  ttl;
  logic [7:0]  proto;
  logic [15:0] old_sum;
  logic [15:0] old_hw;
  logic [15:0] new_hw;
  logic [15:0] new_sum;

  assign ttl     = hdr[TTL_POS +: 8];
  assign proto   = hdr[PROTO_POS +: 8];
  assign old_sum = hdr[CSUM_POS +: 16];
  assign old_hw  = {ttl, proto};
  assign new_hw  = {ttl - 8'd1, proto};
  // incremental update: ~(~HC + ~m + m')
  assign new_sum = ~oc_add(oc_add(~old_sum, ~old_hw), new_hw);

  always_comb begin
    hdr_new = hdr;
    hdr_new[TTL_POS +: 8]   = new_hw[15:8];
    hdr_new[CSUM_POS +: 16] = new_sum;
  end
endmodule

// File: rtl/ipv4_hdr_check.sv
module ipv4_hdr_check
  import ipv4_chk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [HDR_BITS-1:0] out_hdr,
  output logic                out_fwd,
  output logic [2:0]          out_reason
);
  logic                accept_en;
  logic                hdr_done;
  logic [HDR_BITS-1:0] hdr_in;
  logic [HDR_BITS-1:0] hdr_mod;
  drop_rsn_e           rsn;

  assign accept_en = !out_valid || out_ready;

  ipv4_hdr_collect #(.WORDS(HDR_WORDS), .W(WORD_W)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .accept_en (accept_en),
    .in_ready  (in_ready),
    .hdr_done  (hdr_done),
    .hdr       (hdr_in)
  );

  ipv4_hdr_verify u_verify (
    .hdr (hdr_in),
    .rsn (rsn)
  );

  ipv4_ttl_rewrite u_rewrite (
    .hdr     (hdr_in),
    .hdr_new (hdr_mod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hdr    <= '0;
      out_fwd    <= 1'b0;
      out_reason <= 3'd0;
    end else if (hdr_done) begin
      out_valid  <= 1'b1;
      out_fwd    <= (rsn == RSN_OK);
      out_reason <= rsn;
      out_hdr    <= (rsn == RSN_OK) ? hdr_mod : hdr_in;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assert_sum_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fwd) |-> (hdr_fold(out_hdr) == 16'hFFFF));

  assert_ttl_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fwd) |-> (out_hdr[TTL_POS +: 8] != 8'd0));

  assert_fwd_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fwd) |-> (out_hdr[IHL_POS +: 8] == 8'h45));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_hdr) && $stable(out_reason) && $stable(out_fwd)));

  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !hdr_done) |=> !out_valid);

  assert_reason_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_reason <= 3'd4));
endmodule

// File: tb/test_ipv4_hdr_check.sv
`timescale 1ns/1ps
module test_ipv4_hdr_check;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  in_data;
  logic         out_valid;
  logic         out_ready;
  logic [159:0] out_hdr;
  logic         out_fwd;
  logic [2:0]   out_reason;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ipv4_hdr_check i_ipv4_hdr_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_fwd(out_fwd), .out_reason(out_reason)
  );

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w1;
    logic [15:0] tp;   // TTL, protocol
    logic [31:0] w3;
    logic [31:0] w4;
    logic        bad;  // corrupt checksum
    logic [2:0]  rsn;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{32'h45000054, 32'h1c464000, 16'h4001, 32'hc0a80001, 32'hc0a800c7, 1'b0, 3'd0}, // R7
    '{32'h45000054, 32'h1c464000, 16'h0201, 32'hc0a80001, 32'hc0a800c7, 1'b0, 3'd0}, // R5 TTL 2
    '{32'h45000054, 32'h1c464000, 16'h0101, 32'hc0a80001, 32'hc0a800c7, 1'b0, 3'd4}, // R5 TTL 1
    '{32'h45000054, 32'h1c464000, 16'h0006, 32'hc0a80001, 32'hc0a800c7, 1'b0, 3'd4}, // R5 TTL 0
    '{32'h45000054, 32'h1c464000, 16'h4001, 32'hc0a80001, 32'hc0a800c7, 1'b1, 3'd3}, // R4
    '{32'h65000054, 32'h1c464000, 16'h4001, 32'hc0a80001, 32'hc0a800c7, 1'b0, 3'd1}, // R2
    '{32'h44000054, 32'h1c464000, 16'h4001, 32'hc0a80001, 32'hc0a800c7, 1'b0, 3'd2}, // R3 IHL 4
    '{32'h46000054, 32'h1c464000, 16'h4001, 32'hc0a80001, 32'hc0a800c7, 1'b0, 3'd2}, // R3 IHL 6
    '{32'h64000054, 32'h1c464000, 16'h0011, 32'hc0a80001, 32'hc0a800c7, 1'b1, 3'd1}, // R6 all fail
    '{32'h44000054, 32'h1c464000, 16'h0111, 32'hc0a80001, 32'hc0a800c7, 1'b1, 3'd2}, // R6
    '{32'h45000054, 32'h1c464000, 16'h0011, 32'hc0a80001, 32'hc0a800c7, 1'b1, 3'd3}, // R6
    '{32'h450005dc, 32'hffff0000, 16'hff11, 32'h0a000001, 32'hffffffff, 1'b0, 3'd0}, // R7 TTL 255
    '{32'h45ff0014, 32'h00000000, 16'h0300, 32'h00000000, 32'h00000000, 1'b0, 3'd0}  // R7 sparse
  };

  function automatic logic [15:0] ref_csum(input logic [159:0] h);
    logic [31:0] s;
    s = 32'd0;
    for (int i = 0; i < 10; i++) s = s + {16'd0, h[i*16 +: 16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return ~s[15:0];
  endfunction

  function automatic logic [159:0] build(input vec_t v);
    logic [159:0] h;
    h = {v.w0, v.w1, v.tp, 16'h0000, v.w3, v.w4};
    h[79:64] = ref_csum(h) ^ (v.bad ? 16'h0101 : 16'h0000);
    return h;
  endfunction

  function automatic logic [159:0] expect_hdr(input logic [159:0] h, input logic [2:0] rsn);
    logic [159:0] e;
    e = h;
    if (rsn == 3'd0) begin
      e[95:88] = h[95:88] - 8'd1;
      e[79:64] = 16'h0000;
      e[79:64] = ref_csum(e);
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [159:0] h, input int gap);
    for (int k = 0; k < 5; k++) begin
      send_word(h[159-32*k -: 32]);
      if (k < 4) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic check_result(input logic [159:0] h, input logic [2:0] rsn, input string req);
    logic [159:0] e;
    e = expect_hdr(h, rsn);
    chk(out_valid == 1'b1, {req, " valid"}, {159'd0, out_valid}, 160'd1);
    chk(out_reason == rsn, {req, " reason"}, {157'd0, out_reason}, {157'd0, rsn});
    chk(out_fwd == (rsn == 3'd0), {req, " fwd"}, {159'd0, out_fwd}, {159'd0, rsn == 3'd0});
    chk(out_hdr == e, {req, " header"}, out_hdr, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [159:0] ha, hb;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 32'd0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11 out_valid after reset", {159'd0, out_valid}, 160'd0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", {159'd0, in_ready}, 160'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R8 table walk, gap varies to exercise bubbles
    for (int i = 0; i < NV; i++) begin
      ha = build(VEC[i]);
      send_hdr(ha, i % 3);
      check_result(ha, VEC[i].rsn, $sformatf("R1-vec%0d R%0d", i, (VEC[i].rsn == 0) ? 7 : 1 + VEC[i].rsn));
      if (VEC[i].rsn != 0) chk(out_hdr == ha, "R8 dropped header unchanged", out_hdr, ha);
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 single result", {159'd0, out_valid}, 160'd0);
    end

    // R9 stall with next header's first word waiting
    ha = build(VEC[0]);
    hb = build(VEC[11]);
    out_ready = 1'b0;
    send_hdr(ha, 0);
    in_valid = 1'b1;
    in_data  = hb[159:128];
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R9 in_ready low while stalled", {159'd0, in_ready}, 160'd0);
      check_result(ha, 3'd0, "R9 held result");
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R10 result taken once", {159'd0, out_valid}, 160'd0);
    for (int k = 1; k < 5; k++) send_word(hb[159-32*k -: 32]);
    check_result(hb, 3'd0, "R9 next header after release");
    @(negedge clk);

    // R11 partial header discarded by reset
    ha = build(VEC[5]);
    for (int k = 0; k < 3; k++) send_word(ha[159-32*k -: 32]);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    hb = build(VEC[1]);
    send_hdr(hb, 0);
    check_result(hb, 3'd0, "R11 fresh header after reset");
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule